// File: doc/BRIEF.md
# Iterative Stencil Sweep Transfer Controller

This block sequences a fixed number of whole-grid update sweeps for a stencil accelerator. Once the host raises a launch request, it walks the grid in fixed-length bursts. Read commands go to a memory read arbiter. The returned beats collect in an input queue, and that queue feeds a group of parallel processing lanes. Each beat carries one element for every lane. Lane results gather in an output queue. Write bursts to a memory write arbiter drain that queue, and each write burst is acknowledged separately.

Two array base addresses are latched at launch. Within one sweep, one array is the source and the other is the destination. The two swap after every sweep, so each sweep consumes what the previous sweep wrote. A sweep is closed only when every write burst of that sweep has been acknowledged. After the last sweep, a one-cycle done pulse goes back to the host control side. The lanes, the arbiters and the memory are outside the block. The stencil arithmetic is not part of it.

Top module: `sweep_xfer_ctrl`

## Requirements
- R1: After reset the block is idle. It issues no read or write command, presents nothing to the lanes and holds done low until the launch input is sampled high.
- R2: One beat holds NLANES elements, and addresses count in beats. Each sweep covers ceil(DIM0*DIM1*DIM2*DIM3 / NLANES) beats. Read bursts carry BURST beats, except a shorter final burst. Each read address is the source base plus the beat offset of the burst.
- R3: A read burst is requested only when the input queue has room for the whole burst, counting the queued beats and the beats already requested but not yet returned.
- R4: An input beat goes to all lanes in the same cycle, and only when every lane is ready. Results are taken only when every lane offers one and the output queue has room. Every beat of every sweep passes through the lanes exactly once.
- R5: A write burst is requested only when the output queue already holds all of its beats. Write bursts carry BURST beats, except a shorter final burst, at the destination base plus the beat offset.
- R6: Write data beats follow accepted write commands in order, with exactly the command's beat count per burst.
- R7: A sweep ends only when all of its write bursts have been acknowledged. No read command of the next sweep is issued before that point.
- R8: Even-numbered sweeps (counting from 0) read array A and write array B. Odd-numbered sweeps read B and write A.
- R9: After PASSES sweeps, done is high for exactly one cycle and the block returns to idle. A later launch starts again at sweep 0.
- R10: A launch request while the block is running has no effect.
- R11: A read or write command, once presented, keeps its address and length unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_i | input | 1 | Start request from the host control side |
| base_a_i | input | ADDR_W | Beat address of array A, latched at launch |
| base_b_i | input | ADDR_W | Beat address of array B, latched at launch |
| done_o | output | 1 | One-cycle pulse after the last sweep |
| rd_cmd_valid_o | output | 1 | Read burst command valid |
| rd_cmd_ready_i | input | 1 | Read arbiter accepts the command |
| rd_cmd_addr_o | output | ADDR_W | Read burst start address (beats) |
| rd_cmd_len_o | output | LEN_W | Read burst beat count |
| rd_data_valid_i | input | 1 | Returned read beat valid (no backpressure) |
| rd_data_i | input | NLANES*ELEM_W | Returned read beat |
| lane_in_valid_o | output | 1 | Input beat offered to all lanes |
| lane_in_ready_i | input | NLANES | Per-lane input ready |
| lane_in_data_o | output | NLANES*ELEM_W | One element per lane |
| lane_out_valid_i | input | NLANES | Per-lane result valid |
| lane_out_ready_o | output | 1 | Results taken from all lanes this cycle |
| lane_out_data_i | input | NLANES*ELEM_W | One result per lane |
| wr_cmd_valid_o | output | 1 | Write burst command valid |
| wr_cmd_ready_i | input | 1 | Write arbiter accepts the command |
| wr_cmd_addr_o | output | ADDR_W | Write burst start address (beats) |
| wr_cmd_len_o | output | LEN_W | Write burst beat count |
| wr_data_valid_o | output | 1 | Write data beat valid |
| wr_data_ready_i | input | 1 | Write arbiter accepts the data beat |
| wr_data_o | output | NLANES*ELEM_W | Write data beat |
| wr_ack_i | input | 1 | One pulse per completed write burst |

## Verification
The bench builds the block with a 2x3x2x2 grid, four lanes, a burst of 4 beats, three sweeps, an input queue of depth 6 and an output queue of depth 8. With these values, each sweep has one full burst and one partial burst. The odd sweep count leaves the final data in array B, and the non-power-of-two input queue uses the modulo pointer variant and makes the room check tight. Because the lane model adds one to every element, the final contents of both arrays record how many sweeps touched them and in which direction. A second launch checks that the block restarts cleanly.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } sweep_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/sweep_fifo.sv
module sweep_fifo #(
   parameter int WIDTH = 64,
   parameter int DEPTH = 32,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] rdata_o,
   output logic [CNT_W-1:0] count_o,
   output logic             full_o,
   output logic             empty_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sweep_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr_q + 1'b1;
      assign rd_nxt = rd_ptr_q + 1'b1;
   end else begin : g_modulo
      assign wr_nxt = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_nxt = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
   end

   assign full_o  = (cnt_q == CNT_W'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign rdata_o = store[rd_ptr_q];
   assign count_o = cnt_q;

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr_q] <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_nxt;
         if (do_pop)  rd_ptr_q <= rd_nxt;
         cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

endmodule

// File: rtl/sweep_rd_issuer.sv
module sweep_rd_issuer #(
   parameter int ADDR_W      = 32,
   parameter int BEAT_W      = 20,
   parameter int LEN_W       = 5,
   parameter int CNT_W       = 6,
   parameter int TOTAL_BEATS = 648000,
   parameter int BURST       = 16,
   parameter int IQ_DEPTH    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  inq_cnt_i,
   input  logic              beat_in_i,
   output logic              cmd_valid_o,
   input  logic              cmd_ready_i,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic [LEN_W-1:0]  cmd_len_o,
   output logic [CNT_W-1:0]  inflight_o
);

   logic [BEAT_W-1:0] issued_q;
   logic [CNT_W-1:0]  inflight_q;
   logic              valid_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   int                remain;
   logic [LEN_W-1:0]  next_len;
   logic              room_ok, raise;

   always_comb begin
      remain   = TOTAL_BEATS - int'(issued_q);
      next_len = (remain >= BURST) ? LEN_W'(BURST) : LEN_W'(remain);
      room_ok  = (int'(inq_cnt_i) + int'(inflight_q) + int'(next_len)) <= IQ_DEPTH;
      raise    = active_i && !start_i && !valid_q && (remain != 0) && room_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issued_q   <= '0;
         inflight_q <= '0;
         valid_q    <= 1'b0;
         addr_q     <= '0;
         len_q      <= '0;
      end else begin
         if (start_i) begin
            issued_q <= '0;
         end else if (raise) begin
            issued_q <= issued_q + BEAT_W'(next_len);
            addr_q   <= base_i + ADDR_W'(issued_q);
            len_q    <= next_len;
            valid_q  <= 1'b1;
         end
         if (valid_q && cmd_ready_i) valid_q <= 1'b0;
         inflight_q <= inflight_q + (raise ? CNT_W'(next_len) : CNT_W'(0))
                                  - (beat_in_i ? CNT_W'(1) : CNT_W'(0));
      end
   end

   assign cmd_valid_o = valid_q;
   assign cmd_addr_o  = addr_q;
   assign cmd_len_o   = len_q;
   assign inflight_o  = inflight_q;

endmodule

// File: rtl/sweep_wr_issuer.sv
module sweep_wr_issuer #(
   parameter int ADDR_W      = 32,
   parameter int BEAT_W      = 20,
   parameter int LEN_W       = 5,
   parameter int CNT_W       = 6,
   parameter int TOTAL_BEATS = 648000,
   parameter int BURST       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  outq_cnt_i,
   output logic              cmd_valid_o,
   input  logic              cmd_ready_i,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic [LEN_W-1:0]  cmd_len_o,
   output logic              data_valid_o,
   input  logic              data_ready_i,
   output logic              pop_o,
   input  logic              ack_i,
   output logic              pass_done_o
);

   logic [BEAT_W-1:0] planned_q;
   logic [BEAT_W-1:0] acks_q;
   logic [LEN_W-1:0]  left_q;
   logic              valid_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   int                remain;
   logic [LEN_W-1:0]  next_len;
   logic              raise, cmd_hs;

   always_comb begin
      remain   = TOTAL_BEATS - int'(planned_q);
      next_len = (remain >= BURST) ? LEN_W'(BURST) : LEN_W'(remain);
      raise    = active_i && !start_i && !valid_q && (left_q == '0)
                 && (remain != 0) && (int'(outq_cnt_i) >= int'(next_len));
      cmd_hs   = valid_q && cmd_ready_i;
   end

   assign data_valid_o = (left_q != '0);
   assign pop_o        = data_valid_o && data_ready_i;
   assign pass_done_o  = active_i && (remain == 0) && !valid_q
                         && (left_q == '0) && (acks_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         planned_q <= '0;
         acks_q    <= '0;
         left_q    <= '0;
         valid_q   <= 1'b0;
         addr_q    <= '0;
         len_q     <= '0;
      end else begin
         if (start_i) begin
            planned_q <= '0;
         end else if (raise) begin
            planned_q <= planned_q + BEAT_W'(next_len);
            addr_q    <= base_i + ADDR_W'(planned_q);
            len_q     <= next_len;
            valid_q   <= 1'b1;
         end
         if (cmd_hs) begin
            valid_q <= 1'b0;
            left_q  <= len_q;
         end else if (pop_o) begin
            left_q  <= left_q - 1'b1;
         end
         acks_q <= acks_q + BEAT_W'(cmd_hs) - BEAT_W'(ack_i);
      end
   end

   assign cmd_valid_o = valid_q;
   assign cmd_addr_o  = addr_q;
   assign cmd_len_o   = len_q;

endmodule

// File: rtl/sweep_xfer_ctrl.sv
module sweep_xfer_ctrl
   import sweep_pkg::*;
#(
   parameter int NLANES   = 4,
   parameter int ELEM_W   = 16,
   parameter int DIM0     = 60,
   parameter int DIM1     = 60,
   parameter int DIM2     = 20,
   parameter int DIM3     = 36,
   parameter int PASSES   = 67,
   parameter int BURST    = 16,
   parameter int IQ_DEPTH = 32,
   parameter int OQ_DEPTH = 32,
   parameter int ADDR_W   = 32,
   localparam int DATA_W  = NLANES * ELEM_W,
   localparam int LEN_W   = $clog2(BURST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic [ADDR_W-1:0] base_a_i,
   input  logic [ADDR_W-1:0] base_b_i,
   output logic              done_o,
   output logic              rd_cmd_valid_o,
   input  logic              rd_cmd_ready_i,
   output logic [ADDR_W-1:0] rd_cmd_addr_o,
   output logic [LEN_W-1:0]  rd_cmd_len_o,
   input  logic              rd_data_valid_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              lane_in_valid_o,
   input  logic [NLANES-1:0] lane_in_ready_i,
   output logic [DATA_W-1:0] lane_in_data_o,
   input  logic [NLANES-1:0] lane_out_valid_i,
   output logic              lane_out_ready_o,
   input  logic [DATA_W-1:0] lane_out_data_i,
   output logic              wr_cmd_valid_o,
   input  logic              wr_cmd_ready_i,
   output logic [ADDR_W-1:0] wr_cmd_addr_o,
   output logic [LEN_W-1:0]  wr_cmd_len_o,
   output logic              wr_data_valid_o,
   input  logic              wr_data_ready_i,
   output logic [DATA_W-1:0] wr_data_o,
   input  logic              wr_ack_i
);

   localparam int ELEMS       = DIM0 * DIM1 * DIM2 * DIM3;
   localparam int TOTAL_BEATS = ceil_div(ELEMS, NLANES);
   localparam int BEAT_W      = $clog2(TOTAL_BEATS + 1);
   localparam int PASS_W      = $clog2(PASSES + 1);
   localparam int IQ_CNT_W    = $clog2(IQ_DEPTH + 1);
   localparam int OQ_CNT_W    = $clog2(OQ_DEPTH + 1);

   if (BURST < 1 || BURST > IQ_DEPTH || BURST > OQ_DEPTH) begin : g_bad_burst
      $error("sweep_xfer_ctrl: BURST must lie in 1..min(IQ_DEPTH, OQ_DEPTH)");
   end
   if (PASSES < 1 || NLANES < 1 || ELEMS < 1) begin : g_bad_size
      $error("sweep_xfer_ctrl: PASSES, NLANES and grid dimensions must be positive");
   end

   sweep_state_e      state_q;
   logic [PASS_W-1:0] pass_q;
   logic              swap_q;
   logic [ADDR_W-1:0] base_a_q, base_b_q;
   logic              done_q;
   logic              running, pass_done, last_pass, launch_go, advance, finish, start;
   logic [ADDR_W-1:0] rd_base, wr_base;

   logic [IQ_CNT_W-1:0] iq_cnt;
   logic [IQ_CNT_W-1:0] rd_inflight;
   logic                iq_full, iq_empty, iq_pop;
   logic [OQ_CNT_W-1:0] oq_cnt;
   logic                oq_full, oq_empty, oq_pop;

   assign running   = (state_q == ST_RUN);
   assign last_pass = (pass_q == PASS_W'(PASSES - 1));
   assign launch_go = !running && launch_i;
   assign advance   = running && pass_done && !last_pass;
   assign finish    = running && pass_done && last_pass;
   assign start     = launch_go || advance;
   assign rd_base   = swap_q ? base_b_q : base_a_q;
   assign wr_base   = swap_q ? base_a_q : base_b_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         pass_q   <= '0;
         swap_q   <= 1'b0;
         base_a_q <= '0;
         base_b_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= finish;
         if (launch_go) begin
            state_q  <= ST_RUN;
            pass_q   <= '0;
            swap_q   <= 1'b0;
            base_a_q <= base_a_i;
            base_b_q <= base_b_i;
         end else if (advance) begin
            pass_q <= pass_q + 1'b1;
            swap_q <= !swap_q;
         end else if (finish) begin
            state_q <= ST_IDLE;
         end
      end
   end

   assign done_o = done_q;

   sweep_rd_issuer #(
      .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .LEN_W(LEN_W), .CNT_W(IQ_CNT_W),
      .TOTAL_BEATS(TOTAL_BEATS), .BURST(BURST), .IQ_DEPTH(IQ_DEPTH)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .active_i(running), .start_i(start),
      .base_i(rd_base), .inq_cnt_i(iq_cnt), .beat_in_i(rd_data_valid_i),
      .cmd_valid_o(rd_cmd_valid_o), .cmd_ready_i(rd_cmd_ready_i),
      .cmd_addr_o(rd_cmd_addr_o), .cmd_len_o(rd_cmd_len_o),
      .inflight_o(rd_inflight)
   );

   sweep_fifo #(.WIDTH(DATA_W), .DEPTH(IQ_DEPTH)) u_inq (
      .clk(clk), .rst_n(rst_n), .push_i(rd_data_valid_i), .wdata_i(rd_data_i),
      .pop_i(iq_pop), .rdata_o(lane_in_data_o), .count_o(iq_cnt),
      .full_o(iq_full), .empty_o(iq_empty)
   );

   assign lane_in_valid_o  = !iq_empty;
   assign iq_pop           = lane_in_valid_o && (&lane_in_ready_i);
   assign lane_out_ready_o = running && !oq_full && (&lane_out_valid_i);

   sweep_fifo #(.WIDTH(DATA_W), .DEPTH(OQ_DEPTH)) u_outq (
      .clk(clk), .rst_n(rst_n), .push_i(lane_out_ready_o), .wdata_i(lane_out_data_i),
      .pop_i(oq_pop), .rdata_o(wr_data_o), .count_o(oq_cnt),
      .full_o(oq_full), .empty_o(oq_empty)
   );

   sweep_wr_issuer #(
      .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .LEN_W(LEN_W), .CNT_W(OQ_CNT_W),
      .TOTAL_BEATS(TOTAL_BEATS), .BURST(BURST)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .active_i(running), .start_i(start),
      .base_i(wr_base), .outq_cnt_i(oq_cnt),
      .cmd_valid_o(wr_cmd_valid_o), .cmd_ready_i(wr_cmd_ready_i),
      .cmd_addr_o(wr_cmd_addr_o), .cmd_len_o(wr_cmd_len_o),
      .data_valid_o(wr_data_valid_o), .data_ready_i(wr_data_ready_i),
      .pop_o(oq_pop), .ack_i(wr_ack_i), .pass_done_o(pass_done)
   );

endmodule

// File: rtl/sweep_xfer_ctrl_chk.sv
module sweep_xfer_ctrl_chk #(
   parameter int IQ_DEPTH = 32,
   parameter int BURST    = 16,
   parameter int ADDR_W   = 32,
   parameter int LEN_W    = 5,
   parameter int IQ_CNT_W = 6,
   parameter int OQ_CNT_W = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                running,
   input logic                done,
   input logic                rd_cmd_valid,
   input logic                rd_cmd_ready,
   input logic [ADDR_W-1:0]   rd_cmd_addr,
   input logic [LEN_W-1:0]    rd_cmd_len,
   input logic                wr_cmd_valid,
   input logic                wr_cmd_ready,
   input logic [ADDR_W-1:0]   wr_cmd_addr,
   input logic [LEN_W-1:0]    wr_cmd_len,
   input logic [IQ_CNT_W-1:0] iq_cnt,
   input logic [IQ_CNT_W-1:0] rd_inflight,
   input logic [OQ_CNT_W-1:0] oq_cnt
);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!rd_cmd_valid && !wr_cmd_valid));

   a_r2_rd_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd_valid |-> (rd_cmd_len != '0) && (int'(rd_cmd_len) <= BURST));

   a_r3_inq_room: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(iq_cnt) + int'(rd_inflight)) <= IQ_DEPTH);

   a_r5_outq_holds_burst: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd_valid |-> int'(oq_cnt) >= int'(wr_cmd_len));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd_valid && !rd_cmd_ready) |=>
         (rd_cmd_valid && $stable(rd_cmd_addr) && $stable(rd_cmd_len)));

   a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd_valid && !wr_cmd_ready) |=>
         (wr_cmd_valid && $stable(wr_cmd_addr) && $stable(wr_cmd_len)));

endmodule

bind sweep_xfer_ctrl sweep_xfer_ctrl_chk #(
   .IQ_DEPTH(IQ_DEPTH), .BURST(BURST), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
   .IQ_CNT_W(IQ_CNT_W), .OQ_CNT_W(OQ_CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .running(running), .done(done_o),
   .rd_cmd_valid(rd_cmd_valid_o), .rd_cmd_ready(rd_cmd_ready_i),
   .rd_cmd_addr(rd_cmd_addr_o), .rd_cmd_len(rd_cmd_len_o),
   .wr_cmd_valid(wr_cmd_valid_o), .wr_cmd_ready(wr_cmd_ready_i),
   .wr_cmd_addr(wr_cmd_addr_o), .wr_cmd_len(wr_cmd_len_o),
   .iq_cnt(iq_cnt), .rd_inflight(rd_inflight), .oq_cnt(oq_cnt)
);

// File: tb/sweep_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module sweep_xfer_ctrl_bench;

   localparam int NL = 4, EW = 16, DW = NL * EW;
   localparam int PASSES = 3, BURST = 4, IQD = 6, OQD = 8, AW = 32;
   localparam int TB = 6;
   localparam int BPP = 2;
   localparam int BASE_A = 8, BASE_B = 32;
   localparam int LW = $clog2(BURST + 1);

   logic clk = 1'b0, rst_n = 1'b0, launch = 1'b0;
   logic [AW-1:0] base_a = AW'(BASE_A), base_b = AW'(BASE_B);
   logic done;
   logic rd_cmd_valid, rd_cmd_ready = 1'b0;
   logic [AW-1:0] rd_cmd_addr;
   logic [LW-1:0] rd_cmd_len;
   logic rd_data_valid = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic lane_in_valid, lane_out_ready, lane_go = 1'b0;
   logic [NL-1:0] lane_in_ready, lane_out_valid;
   logic [DW-1:0] lane_in_data, lane_out_data;
   logic wr_cmd_valid, wr_cmd_ready = 1'b0;
   logic [AW-1:0] wr_cmd_addr;
   logic [LW-1:0] wr_cmd_len;
   logic wr_data_valid, wr_data_ready = 1'b0;
   logic [DW-1:0] wr_data;
   logic wr_ack = 1'b0;

   always #2.5 clk = ~clk;

   // lane model: every element plus one, all lanes move together
   assign lane_out_valid = {NL{lane_in_valid && lane_go}};
   assign lane_in_ready  = {NL{lane_out_ready}};
   always_comb begin
      for (int k = 0; k < NL; k++)
         lane_out_data[k*EW +: EW] = lane_in_data[k*EW +: EW] + EW'(1);
   end

   sweep_xfer_ctrl #(
      .NLANES(NL), .ELEM_W(EW), .DIM0(2), .DIM1(3), .DIM2(2), .DIM3(2),
      .PASSES(PASSES), .BURST(BURST), .IQ_DEPTH(IQD), .OQ_DEPTH(OQD), .ADDR_W(AW)
   ) u_sweep_xfer_ctrl (
      .clk(clk), .rst_n(rst_n), .launch_i(launch), .base_a_i(base_a), .base_b_i(base_b),
      .done_o(done),
      .rd_cmd_valid_o(rd_cmd_valid), .rd_cmd_ready_i(rd_cmd_ready),
      .rd_cmd_addr_o(rd_cmd_addr), .rd_cmd_len_o(rd_cmd_len),
      .rd_data_valid_i(rd_data_valid), .rd_data_i(rd_data),
      .lane_in_valid_o(lane_in_valid), .lane_in_ready_i(lane_in_ready),
      .lane_in_data_o(lane_in_data), .lane_out_valid_i(lane_out_valid),
      .lane_out_ready_o(lane_out_ready), .lane_out_data_i(lane_out_data),
      .wr_cmd_valid_o(wr_cmd_valid), .wr_cmd_ready_i(wr_cmd_ready),
      .wr_cmd_addr_o(wr_cmd_addr), .wr_cmd_len_o(wr_cmd_len),
      .wr_data_valid_o(wr_data_valid), .wr_data_ready_i(wr_data_ready),
      .wr_data_o(wr_data), .wr_ack_i(wr_ack)
   );

   logic [DW-1:0] mem [0:63];
   int exp_rd_addr[$], exp_rd_len[$], exp_rd_pass[$], exp_wr_addr[$], exp_wr_len[$];
   int pend_rd[$], wb_addr[$], wb_len[$], ack_at[$];
   int cur_addr = 0, cur_left = 0;
   int acks_given = 0, done_seen = 0, unexpected = 0, lane_xfers = 0;
   int iq_occ = 0, oq_occ = 0, cyc = 0;
   int checks = 0, fails = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] beat_init(input int i);
      logic [DW-1:0] v;
      for (int k = 0; k < NL; k++) v[k*EW +: EW] = EW'(i * 16 + k * 3 + 1);
      return v;
   endfunction

   function automatic logic [DW-1:0] beat_plus(input logic [DW-1:0] v, input int n);
      logic [DW-1:0] r;
      for (int k = 0; k < NL; k++) r[k*EW +: EW] = v[k*EW +: EW] + EW'(n);
      return r;
   endfunction

   task automatic build_expect();
      for (int p = 0; p < PASSES; p++) begin
         int src, dst;
         src = (p % 2 == 0) ? BASE_A : BASE_B;
         dst = (p % 2 == 0) ? BASE_B : BASE_A;
         for (int b = 0; b < TB; b += BURST) begin
            int len;
            len = (TB - b >= BURST) ? BURST : TB - b;
            exp_rd_addr.push_back(src + b); exp_rd_len.push_back(len);
            exp_rd_pass.push_back(p);
            exp_wr_addr.push_back(dst + b); exp_wr_len.push_back(len);
         end
      end
   endtask

   // reference model of the surrounding arbiters, memory and queues
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         rd_cmd_ready  = (cyc % 3) != 0;
         wr_cmd_ready  = (cyc % 4) != 2;
         wr_data_ready = (cyc % 3) != 1;
         lane_go       = (cyc % 7) != 3;
         wr_ack = 1'b0;
         if (ack_at.size() > 0 && ack_at[0] <= cyc) begin
            wr_ack = 1'b1; void'(ack_at.pop_front()); acks_given++;
         end
         rd_data_valid = 1'b0;
         if (pend_rd.size() > 0 && (cyc % 5) != 1) begin
            rd_data_valid = 1'b1; rd_data = mem[pend_rd[0]];
         end
         #1;
         if (!rst_n) continue;
         if (rd_cmd_valid && rd_cmd_ready) begin
            if (exp_rd_addr.size() == 0) begin
               unexpected++;
               check(1'b0, "R10", "read command with none expected", rd_cmd_addr, -1);
            end else begin
               check(int'(rd_cmd_addr) == exp_rd_addr[0], "R8", "read address",
                     rd_cmd_addr, exp_rd_addr[0]);
               check(int'(rd_cmd_len) == exp_rd_len[0], "R2", "read length",
                     rd_cmd_len, exp_rd_len[0]);
               check(acks_given >= BPP * exp_rd_pass[0], "R7", "acks before next sweep read",
                     acks_given, BPP * exp_rd_pass[0]);
               check(iq_occ + pend_rd.size() + int'(rd_cmd_len) <= IQD, "R3", "input room",
                     iq_occ + pend_rd.size() + int'(rd_cmd_len), IQD);
               for (int i = 0; i < int'(rd_cmd_len); i++) pend_rd.push_back(int'(rd_cmd_addr) + i);
               void'(exp_rd_addr.pop_front()); void'(exp_rd_len.pop_front());
               void'(exp_rd_pass.pop_front());
            end
         end
         if (rd_data_valid) begin void'(pend_rd.pop_front()); iq_occ++; end
         if (lane_in_valid && (&lane_in_ready)) iq_occ--;
         if (lane_out_ready) begin oq_occ++; lane_xfers++; end
         if (wr_cmd_valid && wr_cmd_ready) begin
            if (exp_wr_addr.size() == 0) begin
               unexpected++;
               check(1'b0, "R10", "write command with none expected", wr_cmd_addr, -1);
            end else begin
               check(int'(wr_cmd_addr) == exp_wr_addr[0], "R8", "write address",
                     wr_cmd_addr, exp_wr_addr[0]);
               check(int'(wr_cmd_len) == exp_wr_len[0], "R5", "write length",
                     wr_cmd_len, exp_wr_len[0]);
               check(oq_occ >= int'(wr_cmd_len), "R5", "output queue holds burst",
                     oq_occ, wr_cmd_len);
               wb_addr.push_back(int'(wr_cmd_addr)); wb_len.push_back(int'(wr_cmd_len));
               void'(exp_wr_addr.pop_front()); void'(exp_wr_len.pop_front());
            end
         end
         if (wr_data_valid && wr_data_ready) begin
            if (cur_left == 0) begin
               if (wb_addr.size() == 0) begin
                  check(1'b0, "R6", "write data without command", 0, 1);
               end else begin
                  cur_addr = wb_addr.pop_front(); cur_left = wb_len.pop_front();
               end
            end
            if (cur_left > 0) begin
               mem[cur_addr[5:0]] = wr_data; cur_addr++; cur_left--; oq_occ--;
               if (cur_left == 0) ack_at.push_back(cyc + 2);
            end
         end
         if (done) begin
            done_seen++;
            check(exp_wr_addr.size() == 0 && exp_rd_addr.size() == 0 && ack_at.size() == 0
                  && cur_left == 0, "R9", "done only after last ack",
                  exp_wr_addr.size() + ack_at.size(), 0);
         end
      end
   end

   task automatic run_and_wait(input int target, input bit relaunch);
      int n;
      build_expect();
      @(negedge clk); launch = 1'b1;
      @(negedge clk); launch = 1'b0;
      if (relaunch) begin
         repeat (15) @(negedge clk);
         launch = 1'b1;
         @(negedge clk); launch = 1'b0;
      end
      n = 0;
      while (done_seen < target && n < 5000) begin @(negedge clk); n++; end
      if (done_seen < target) check(1'b0, "R9", "watchdog expired waiting for done", done_seen, target);
      repeat (20) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      for (int i = 0; i < TB; i++) mem[BASE_A + i] = beat_init(i);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!rd_cmd_valid && !wr_cmd_valid && !done && !lane_in_valid && !wr_data_valid,
            "R1", "idle outputs after reset", {rd_cmd_valid, wr_cmd_valid, done}, 0);
      repeat (10) @(negedge clk);
      check(unexpected == 0, "R1", "no command before launch", unexpected, 0);

      // first run with a launch pulse while busy (R10)
      run_and_wait(1, 1'b1);
      check(done_seen == 1, "R10", "single completion despite second launch", done_seen, 1);
      check(exp_rd_addr.size() == 0 && exp_wr_addr.size() == 0, "R7",
            "all sweeps issued", exp_rd_addr.size() + exp_wr_addr.size(), 0);
      check(lane_xfers == TB * PASSES, "R4", "beats through lanes", lane_xfers, TB * PASSES);
      for (int i = 0; i < TB; i++) begin
         check(mem[BASE_B + i] == beat_plus(beat_init(i), 3), "R8", "array B after run 1",
               mem[BASE_B + i][15:0], beat_plus(beat_init(i), 3)[15:0]);
         check(mem[BASE_A + i] == beat_plus(beat_init(i), 2), "R6", "array A after run 1",
               mem[BASE_A + i][15:0], beat_plus(beat_init(i), 2)[15:0]);
      end

      // second run restarts at sweep 0 reading array A (R9)
      run_and_wait(2, 1'b0);
      check(done_seen == 2, "R9", "second completion", done_seen, 2);
      check(unexpected == 0, "R10", "no stray command", unexpected, 0);
      for (int i = 0; i < TB; i++)
         check(mem[BASE_B + i] == beat_plus(beat_init(i), 5), "R9", "array B after run 2",
               mem[BASE_B + i][15:0], beat_plus(beat_init(i), 5)[15:0]);

      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      fails++; checks++;
      $display("FAIL R9 global watchdog: actual %0d expected %0d", done_seen, 2);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule